// File: doc/BRIEF.md
# Split Two-Way Address Translation Cache

This block caches virtual-to-physical page translations for a processor core. It has two independent banks: one serves instruction fetches and one serves data accesses. Each bank is two-way set associative. The set is chosen by the low bits of the virtual page number. Pages are 4 KiB. A translation is the stored page frame joined to the 12-bit page offset of the request.

A lookup port takes a virtual address and an access kind, and answers in the same cycle with hit and physical address. The access kind is fetch, read, write or quiet probe. The recency flags change at the next clock edge.

A miss tells an outside page-table walker to run. The walker then installs the result through the refill port. Write accesses to a page whose changed flag is not yet set are reported as misses, so that the walker can record the modification.

An invalidate port takes a virtual address. It clears both ways of that set in both banks, whatever tags they hold.

Top module: `split_tlb`

## Requirements
- R1: After synchronous reset every entry of both banks is invalid, so every lookup in every set of either bank misses.
- R2: A lookup hits only when a valid way of the indexed set holds a tag equal to the request's virtual address bits [31:12]. On a hit, `lk_paddr` is the stored 20-bit frame in bits [31:12] and the request's bits [11:0] in bits [11:0], with no cycle of delay.
- R3: Access kind encoding on `lk_kind` is 0 fetch, 1 read, 2 write, 3 quiet probe. Fetches use only the instruction bank, and the other three kinds use only the data bank. A refill goes to the instruction bank when `rf_instr` is 1, and to the data bank otherwise.
- R4: The set index is virtual address bits [17:12]. Sets are independent. Two pages with the same index and different tags can be resident together, one in each way.
- R5: When both ways of a set match, way 0 supplies the translation.
- R6: A hit by a fetch, read or write makes the hit way most recent and the other way not most recent, from the next cycle on.
- R7: A quiet probe that hits returns the translation but leaves both recency flags of the set unchanged.
- R8: A write that matches an entry whose changed flag is clear reports a miss and leaves recency unchanged. A write that matches an entry whose changed flag is set hits.
- R9: A refill writes way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way that is not most recent. The written way becomes most recent and takes its changed flag from `rf_changed`.
- R10: An invalidate clears both ways of the set selected by `inv_vaddr[17:12]` in both banks, without comparing tags. Other sets keep their contents.
- R11: If an invalidate and a refill address the same set in the same cycle, the set ends up empty. A refill to a different set in that cycle completes normally.
- R12: With `lk_valid` low, `lk_hit` is 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 quiet probe |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Translation found and usable |
| lk_paddr | output | 32 | Translated physical address (meaningful when lk_hit is 1) |
| rf_valid | input | 1 | Refill request present |
| rf_instr | input | 1 | Refill targets the instruction bank when 1 |
| rf_vaddr | input | 32 | Virtual address of the page being installed |
| rf_frame | input | 20 | Physical page frame for the new entry |
| rf_changed | input | 1 | Changed flag for the new entry |
| inv_valid | input | 1 | Invalidate request present |
| inv_vaddr | input | 32 | Virtual address selecting the set to clear |

## Verification
The bench builds the block with its default six index bits, which gives 64 sets in each of the two banks. That configuration is small enough to fill and probe every set of both banks. The sweep therefore covers the reset state, bank steering, index decoding and tag-blind set invalidation in every set, not just a sample. Per-set scenarios then exercise the replacement order, way-0 priority, probe and write-guard behaviour on recency, and the simultaneous invalidate/refill collisions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_BITS  = 12;
    localparam int TAG_W      = VA_W - PAGE_BITS;
    localparam int FRAME_W    = 20;
    localparam int PA_W       = FRAME_W + PAGE_BITS;
    localparam int WAYS       = 2;
    localparam int SET_BITS_D = 6;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_PROBE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic               valid;
        logic               mru;
        logic               chg;
        logic [TAG_W-1:0]   tag;
        logic [FRAME_W-1:0] frame;
    } tlb_entry_t;

    // Replacement choice: first invalid way, else the way not most recent.
    function automatic logic pick_victim(input logic [WAYS-1:0] vld,
                                         input logic [WAYS-1:0] mru);
        if (!vld[0])      return 1'b0;
        else if (!vld[1]) return 1'b1;
        else if (!mru[0]) return 1'b0;
        else              return 1'b1;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]  vld,
    input  logic [TAG_W-1:0] tag0,
    input  logic [TAG_W-1:0] tag1,
    input  logic [TAG_W-1:0] req_tag,
    output logic             any_hit,
    output logic             hit_way
);
    logic [WAYS-1:0] eq;

    always_comb begin
        eq[0]   = vld[0] && (tag0 == req_tag);
        eq[1]   = vld[1] && (tag1 == req_tag);
        any_hit = |eq;
        // Way 0 has priority when both match.
        hit_way = eq[0] ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0] vld,
    input  logic [WAYS-1:0] mru,
    output logic            way
);
    always_comb way = pick_victim(vld, mru);
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlb_pkg::*;
#(
    parameter int SET_BITS = SET_BITS_D
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_en,
    input  logic               lk_upd,
    input  logic               lk_write,
    input  logic [TAG_W-1:0]   lk_vpn,
    output logic               hit,
    output logic [FRAME_W-1:0] frame,
    input  logic               rf_en,
    input  logic [TAG_W-1:0]   rf_vpn,
    input  logic [FRAME_W-1:0] rf_frame,
    input  logic               rf_chg,
    input  logic               inv_en,
    input  logic [SET_BITS-1:0] inv_set
);
    localparam int SETS = 1 << SET_BITS;

    tlb_entry_t mem [SETS][WAYS];

    logic [SET_BITS-1:0] lk_set, rf_set;
    logic                any_hit, hit_way, vic;
    logic [WAYS-1:0]     lk_vld, rf_vld, rf_mru;
    tlb_entry_t          sel;

    assign lk_set = lk_vpn[SET_BITS-1:0];
    assign rf_set = rf_vpn[SET_BITS-1:0];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_vld[w] = mem[lk_set][w].valid;
            rf_vld[w] = mem[rf_set][w].valid;
            rf_mru[w] = mem[rf_set][w].mru;
        end
    end

    tlb_match u_match (
        .vld     (lk_vld),
        .tag0    (mem[lk_set][0].tag),
        .tag1    (mem[lk_set][1].tag),
        .req_tag (lk_vpn),
        .any_hit (any_hit),
        .hit_way (hit_way)
    );

    tlb_victim u_victim (
        .vld (rf_vld),
        .mru (rf_mru),
        .way (vic)
    );

    always_comb begin
        sel   = mem[lk_set][hit_way];
        hit   = lk_en && any_hit && !(lk_write && !sel.chg);
        frame = sel.frame;
    end

    // Later statements take precedence: invalidate > refill > recency.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem[s][w] <= '0;
        end else begin
            if (hit && lk_upd) begin
                mem[lk_set][hit_way].mru  <= 1'b1;
                mem[lk_set][~hit_way].mru <= 1'b0;
            end
            if (rf_en) begin
                mem[rf_set][vic]       <= '{valid: 1'b1, mru: 1'b1, chg: rf_chg,
                                            tag: rf_vpn, frame: rf_frame};
                mem[rf_set][~vic].mru  <= 1'b0;
            end
            if (inv_en) begin
                mem[inv_set][0].valid <= 1'b0;
                mem[inv_set][1].valid <= 1'b0;
            end
        end
    end

    logic quiet;
    assign quiet = !rf_en && !inv_en;

    assert_inv_clears_R10: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> !mem[$past(inv_set)][0].valid && !mem[$past(inv_set)][1].valid);

    assert_inv_beats_refill_R11: assert property (@(posedge clk) disable iff (rst)
        (inv_en && rf_en && inv_set == rf_set) |=> !mem[$past(rf_set)][$past(vic)].valid);

    assert_hit_recency_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && lk_upd && quiet) |=>
            mem[$past(lk_set)][$past(hit_way)].mru && !mem[$past(lk_set)][!$past(hit_way)].mru);

    assert_probe_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (lk_en && !lk_upd && quiet) |=>
            mem[$past(lk_set)][0].mru == $past(mem[lk_set][0].mru) &&
            mem[$past(lk_set)][1].mru == $past(mem[lk_set][1].mru));

    assert_write_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (lk_en && lk_write && !hit && quiet) |=>
            mem[$past(lk_set)][0].mru == $past(mem[lk_set][0].mru) &&
            mem[$past(lk_set)][1].mru == $past(mem[lk_set][1].mru));

    assert_refill_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (rf_en && !inv_en) |=>
            mem[$past(rf_set)][$past(vic)].valid && mem[$past(rf_set)][$past(vic)].mru &&
            mem[$past(rf_set)][$past(vic)].tag == $past(rf_vpn));

    assert_mru_single_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem[lk_set][0].mru, mem[lk_set][1].mru}));

endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import tlb_pkg::*;
#(
    parameter int SET_BITS = SET_BITS_D
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [1:0]         lk_kind,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               lk_hit,
    output logic [PA_W-1:0]    lk_paddr,
    input  logic               rf_valid,
    input  logic               rf_instr,
    input  logic [VA_W-1:0]    rf_vaddr,
    input  logic [FRAME_W-1:0] rf_frame,
    input  logic               rf_changed,
    input  logic               inv_valid,
    input  logic [VA_W-1:0]    inv_vaddr
);
    localparam int BANKS = 2;   // 0 = data, 1 = instruction

    acc_kind_e             kind;
    logic                  use_ins;
    logic [BANKS-1:0]      bank_hit;
    logic [FRAME_W-1:0]    bank_frame [BANKS];
    logic [SET_BITS-1:0]   inv_set;

    assign kind    = acc_kind_e'(lk_kind);
    assign use_ins = (kind == ACC_FETCH);
    assign inv_set = inv_vaddr[PAGE_BITS +: SET_BITS];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{rf_vaddr[PAGE_BITS-1:0], inv_vaddr};

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        localparam logic IS_INS = (g == 1);
        tlb_bank #(.SET_BITS(SET_BITS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lk_en    (lk_valid && (use_ins == IS_INS)),
            .lk_upd   (kind != ACC_PROBE),
            .lk_write (kind == ACC_WRITE),
            .lk_vpn   (lk_vaddr[VA_W-1:PAGE_BITS]),
            .hit      (bank_hit[g]),
            .frame    (bank_frame[g]),
            .rf_en    (rf_valid && (rf_instr == IS_INS)),
            .rf_vpn   (rf_vaddr[VA_W-1:PAGE_BITS]),
            .rf_frame (rf_frame),
            .rf_chg   (rf_changed),
            .inv_en   (inv_valid),
            .inv_set  (inv_set)
        );
    end

    assign lk_hit   = |bank_hit;
    assign lk_paddr = {use_ins ? bank_frame[1] : bank_frame[0], lk_vaddr[PAGE_BITS-1:0]};

    assert_idle_nohit_R12: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !lk_hit);

    assert_one_bank_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_hit));

endmodule

// File: tb/tb_split_tlb.sv
module tb_split_tlb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, rf_valid = 0, rf_instr = 0, rf_changed = 0, inv_valid = 0;
    logic [1:0]  lk_kind = 0;
    logic [31:0] lk_vaddr = 0, rf_vaddr = 0, inv_vaddr = 0;
    logic [19:0] rf_frame = 0;
    logic        lk_hit;
    logic [31:0] lk_paddr;

    int n_chk = 0, n_fail = 0;

    localparam logic [1:0] K_F = 2'd0, K_R = 2'd1, K_W = 2'd2, K_P = 2'd3;

    always #10 clk = ~clk;   // 50 MHz

    split_tlb dut (.*);

    function automatic logic [31:0] va(int s, int w, int off);
        return {14'(w * 37 + 3), 6'(s), 12'(off)};
    endfunction
    function automatic logic [19:0] frm(int s, int w, int ins);
        return 20'(20'h40000 + s * 16 + w * 4 + ins * 2 + 1);
    endfunction

    task automatic lookup(input logic v, input logic [1:0] k, input logic [31:0] a,
                          input logic eh, input logic [19:0] ef, input string rq);
        @(negedge clk);
        lk_valid = v; lk_kind = k; lk_vaddr = a;
        #2;
        n_chk++;
        if (lk_hit !== eh || (eh && lk_paddr !== {ef, a[11:0]})) begin
            n_fail++;
            $display("FAIL %s: va=%h hit=%b pa=%h expected hit=%b pa=%h",
                     rq, a, lk_hit, lk_paddr, eh, {ef, a[11:0]});
        end
        @(posedge clk); #1;
        lk_valid = 0;
    endtask

    task automatic cycle(input logic rv, input logic ri, input logic [31:0] ra,
                         input logic [19:0] rfm, input logic rc,
                         input logic iv, input logic [31:0] ia);
        @(negedge clk);
        rf_valid = rv; rf_instr = ri; rf_vaddr = ra; rf_frame = rfm; rf_changed = rc;
        inv_valid = iv; inv_vaddr = ia;
        @(posedge clk); #1;
        rf_valid = 0; inv_valid = 0;
    endtask

    task automatic refill(input logic ins, input logic [31:0] a, input logic [19:0] f, input logic c);
        cycle(1'b1, ins, a, f, c, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: empty after reset, every set, both banks
        for (int s = 0; s < 64; s++) begin
            lookup(1, K_F, va(s, 0, s), 0, 0, "R1 reset fetch");
            lookup(1, K_R, va(s, 0, s), 0, 0, "R1 reset read");
        end

        // Fill: instruction bank one way, data bank two ways
        for (int s = 0; s < 64; s++) begin
            refill(1, va(s, 0, 0), frm(s, 0, 1), 1);
            refill(0, va(s, 0, 0), frm(s, 0, 0), 1);
            refill(0, va(s, 1, 0), frm(s, 1, 0), 1);
        end
        for (int s = 0; s < 64; s++) begin
            lookup(1, K_F, va(s, 0, s * 61), 1, frm(s, 0, 1), "R2 R3 fetch bank");
            lookup(1, K_R, va(s, 0, s * 67), 1, frm(s, 0, 0), "R2 R3 read bank");
            lookup(1, K_W, va(s, 1, 4095 - s), 1, frm(s, 1, 0), "R4 second way");
            lookup(1, K_F, va(s, 1, s), 0, 0, "R3 fetch misses data-only page");
            lookup(1, K_R, va(s, 2, s), 0, 0, "R2 tag mismatch");
        end
        lookup(1, K_P, va(9, 0, 5), 1, frm(9, 0, 0), "R3 probe uses data bank");
        lookup(0, K_R, va(9, 0, 5), 0, 0, "R12 idle no hit");

        // R10: tag-blind invalidate of even sets; odd sets kept
        for (int s = 0; s < 64; s += 2) cycle(0, 0, 0, 0, 0, 1, va(s, 9, 0));
        for (int s = 0; s < 64; s++) begin
            lookup(1, K_F, va(s, 0, 1), s % 2 == 1, frm(s, 0, 1), "R10 instr bank");
            lookup(1, K_R, va(s, 1, 1), s % 2 == 1, frm(s, 1, 0), "R10 data bank");
        end

        // R5: duplicate tag, way 0 wins
        refill(0, va(2, 0, 0), 20'h11111, 1);
        refill(0, va(2, 0, 0), 20'h22222, 1);
        lookup(1, K_R, va(2, 0, 7), 1, 20'h11111, "R5 way0 priority");

        // R6 + R9: read makes A recent; refill C evicts B
        refill(0, va(4, 0, 0), frm(4, 0, 0), 1);
        refill(0, va(4, 1, 0), frm(4, 1, 0), 1);
        lookup(1, K_R, va(4, 0, 3), 1, frm(4, 0, 0), "R6 hit A");
        refill(0, va(4, 2, 0), frm(4, 2, 0), 1);
        lookup(1, K_R, va(4, 1, 3), 0, 0, "R6 R9 B evicted");
        lookup(1, K_R, va(4, 0, 3), 1, frm(4, 0, 0), "R6 A kept");
        lookup(1, K_R, va(4, 2, 3), 1, frm(4, 2, 0), "R9 C installed");

        // R7: probe does not refresh A; refill C evicts A
        refill(0, va(6, 0, 0), frm(6, 0, 0), 1);
        refill(0, va(6, 1, 0), frm(6, 1, 0), 1);
        lookup(1, K_P, va(6, 0, 3), 1, frm(6, 0, 0), "R7 probe hits");
        refill(0, va(6, 2, 0), frm(6, 2, 0), 1);
        lookup(1, K_R, va(6, 0, 3), 0, 0, "R7 A evicted");
        lookup(1, K_R, va(6, 1, 3), 1, frm(6, 1, 0), "R7 B kept");

        // R8: write to clean page misses and does not refresh it
        refill(0, va(8, 0, 0), frm(8, 0, 0), 0);
        refill(0, va(8, 1, 0), frm(8, 1, 0), 1);
        lookup(1, K_W, va(8, 0, 3), 0, 0, "R8 clean write misses");
        lookup(1, K_W, va(8, 1, 3), 1, frm(8, 1, 0), "R8 dirty write hits");
        lookup(1, K_W, va(8, 0, 3), 0, 0, "R8 clean write again");
        refill(0, va(8, 2, 0), frm(8, 2, 0), 1);
        lookup(1, K_R, va(8, 0, 3), 0, 0, "R8 no recency from blocked write");
        lookup(1, K_R, va(8, 1, 3), 1, frm(8, 1, 0), "R8 B kept");

        // R11: collision on same set vs different set
        cycle(1, 0, va(12, 0, 0), frm(12, 0, 0), 1, 1, va(12, 5, 0));
        lookup(1, K_R, va(12, 0, 3), 0, 0, "R11 invalidate wins");
        cycle(1, 0, va(16, 0, 0), frm(16, 0, 0), 1, 1, va(15, 5, 0));
        lookup(1, K_R, va(16, 0, 3), 1, frm(16, 0, 0), "R11 other set refilled");
        lookup(1, K_R, va(15, 1, 3), 0, 0, "R11 invalidated set empty");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule